// File: doc/BRIEF.md
# Bidirectional GPIO Port with Standby Control

This block controls a port of general-purpose pins. Each pin has a data latch and a direction bit. A pin can instead be handed to an LCD common-output driver, whose drive value and drive enable arrive as plain inputs. A small register bus writes and reads four registers. Reads carry a read-modify-write qualifier, which chooses between the output latch and the pin level for pins that are inputs. The block drives an output value and an output enable for each pin toward the pad models. It samples the pad inputs through a synchronizer.

Two standby signals, stop and watch, work together with a pin-hold control bit. When the bit is set and the device enters either standby state, every pin floats and every input is clamped low. When the bit is clear, the pins keep their current behaviour through standby. A global input-control bit gates the whole port: while it is 0, no pin drives and the input path delivers zeros.

Top module: `gpio_port_standby`

## Requirements
- R1: After reset, the data latch, direction and function-select registers read 0. The control register reads 0x01 (input enabled, hold off), and every `pad_oe` bit is 0.
- R2: Registers are selected by `bus_addr`: 0 is data, 1 is direction, 2 is function select and 3 is control. In the control register, bit 0 is input control and bit 1 is pin hold. Registers 0 to 2 read back what was written. Register 3 reads back only bits 1:0, and its upper bits read 0.
- R3: When a pin has direction 1, function select 0 and input control 1, and no hold-standby is active, the pin drives `pad_oe`=1 with `pad_out` equal to its latch bit. This holds from the clock edge of the write onward.
- R4: A data write always updates the latch. Pins with direction 0 do not drive it (`pad_oe`=0). Setting direction to 1 later drives the stored value.
- R5: A normal data read (`bus_rmw`=0) returns the latch bit for direction-1 pins and the synchronized pad level for direction-0 pins. A pad change made before clock edge k is first visible after edge k+1.
- R6: A data read with `bus_rmw`=1 returns the latch for every pin, whatever the pin's direction.
- R7: While input control is 0, every `pad_oe` is 0 and direction-0 pins read as 0 on normal reads. Read-modify-write reads still return the latch.
- R8: A pin with function select 1 and direction 0 drives `pad_oe` from `lcd_com_oe` and `pad_out` from `lcd_com_val`, ignoring the latch. With function select 1 and direction 1, the pin does not drive.
- R9: With pin hold 1 and either `stop_mode` or `watch_mode` high, every `pad_oe` is 0 and the input path delivers 0, so direction-0 pins read 0 on normal reads.
- R10: With pin hold 0, asserting `stop_mode` or `watch_mode` changes neither pin drive, output levels nor input reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | PIN_W | Write data |
| bus_rmw | input | 1 | Read is part of a read-modify-write |
| bus_rdata | output | PIN_W | Read data, combinational from address |
| pad_in | input | PIN_W | Pad input levels |
| pad_out | output | PIN_W | Pad output values |
| pad_oe | output | PIN_W | Pad output enables |
| lcd_com_val | input | PIN_W | LCD common drive values |
| lcd_com_oe | input | PIN_W | LCD common drive enables |
| stop_mode | input | 1 | Device is in stop standby |
| watch_mode | input | 1 | Device is in watch standby |

## Verification
The bench uses a port with some pins in each direction to confirm that a normal read mixes latch and pad bits per pin. A read-modify-write read must return the pure latch; a design that muxed on direction for every read would corrupt bit-set sequences. It steps a pad change one clock at a time, so a synchronizer with the wrong depth shows up as an early or late read value. It checks that turning input control off, or entering standby with hold set, clamps both drive and input, while standby with hold clear changes nothing. A design that checked only one standby signal, or that ignored hold, fails those checks. LCD-selected pins are driven with values that differ from the latch, so a design that drove the latch on those pins, or that let a pin with direction 1 drive in LCD mode, reports a mismatch.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int unsigned REG_ADDR_W    = 2;
   localparam int unsigned CTRL_PIC_BIT  = 0;
   localparam int unsigned CTRL_HOLD_BIT = 1;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_DATA = 2'd0,
      REG_DIR  = 2'd1,
      REG_FSEL = 2'd2,
      REG_CTRL = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned PIN_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [REG_ADDR_W-1:0] addr,
   input  logic [PIN_W-1:0]      wdata,
   output logic [PIN_W-1:0]      data_q,
   output logic [PIN_W-1:0]      dir_q,
   output logic [PIN_W-1:0]      fsel_q,
   output logic                  pic_q,
   output logic                  hold_q
);
   if (PIN_W < 2) begin : g_bad_width
      $error("gpio_port_regs: PIN_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
         fsel_q <= '0;
         pic_q  <= 1'b1;
         hold_q <= 1'b0;
      end else if (we) begin
         case (reg_sel_e'(addr))
            REG_DATA: data_q <= wdata;
            REG_DIR:  dir_q  <= wdata;
            REG_FSEL: fsel_q <= wdata;
            REG_CTRL: begin
               pic_q  <= wdata[CTRL_PIC_BIT];
               hold_q <= wdata[CTRL_HOLD_BIT];
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/gpio_port_insync.sv
module gpio_port_insync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_depth
      $error("gpio_port_insync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg[s] <= '0;
         end else if (s == 0) begin
            stg[s] <= din;
         end else begin
            stg[s] <= stg[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
   input  logic latch,
   input  logic dir,
   input  logic fsel,
   input  logic pic,
   input  logic force_hiz,
   input  logic lcd_val,
   input  logic lcd_oe,
   input  logic sync_in,
   output logic out,
   output logic oe,
   output logic in_gated
);
   logic active;

   assign active   = pic & ~force_hiz;
   assign in_gated = sync_in & active;

   always_comb begin
      if (fsel) begin
         out = lcd_val;
         oe  = lcd_oe & ~dir & active;
      end else begin
         out = latch;
         oe  = dir & active;
      end
   end
endmodule

// File: rtl/gpio_port_standby.sv
module gpio_port_standby
   import gpio_port_pkg::*;
#(
   parameter int unsigned PIN_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_we,
   input  logic [REG_ADDR_W-1:0] bus_addr,
   input  logic [PIN_W-1:0]      bus_wdata,
   input  logic                  bus_rmw,
   output logic [PIN_W-1:0]      bus_rdata,
   input  logic [PIN_W-1:0]      pad_in,
   output logic [PIN_W-1:0]      pad_out,
   output logic [PIN_W-1:0]      pad_oe,
   input  logic [PIN_W-1:0]      lcd_com_val,
   input  logic [PIN_W-1:0]      lcd_com_oe,
   input  logic                  stop_mode,
   input  logic                  watch_mode
);
   logic [PIN_W-1:0] data_q, dir_q, fsel_q;
   logic             pic_q, hold_q;
   logic [PIN_W-1:0] sync_in, in_gated;
   logic             force_hiz;

   gpio_port_regs #(.PIN_W(PIN_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (bus_we),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .data_q (data_q),
      .dir_q  (dir_q),
      .fsel_q (fsel_q),
      .pic_q  (pic_q),
      .hold_q (hold_q)
   );

   gpio_port_insync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pad_in),
      .dout  (sync_in)
   );

   assign force_hiz = (stop_mode | watch_mode) & hold_q;

   for (genvar p = 0; p < PIN_W; p++) begin : g_pin
      gpio_pin_cell u_cell (
         .latch     (data_q[p]),
         .dir       (dir_q[p]),
         .fsel      (fsel_q[p]),
         .pic       (pic_q),
         .force_hiz (force_hiz),
         .lcd_val   (lcd_com_val[p]),
         .lcd_oe    (lcd_com_oe[p]),
         .sync_in   (sync_in[p]),
         .out       (pad_out[p]),
         .oe        (pad_oe[p]),
         .in_gated  (in_gated[p])
      );
   end

   always_comb begin
      bus_rdata = '0;
      case (reg_sel_e'(bus_addr))
         REG_DATA: bus_rdata = bus_rmw ? data_q
                                       : ((dir_q & data_q) | (~dir_q & in_gated));
         REG_DIR:  bus_rdata = dir_q;
         REG_FSEL: bus_rdata = fsel_q;
         REG_CTRL: begin
            bus_rdata[CTRL_PIC_BIT]  = pic_q;
            bus_rdata[CTRL_HOLD_BIT] = hold_q;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int unsigned PIN_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_we,
   input logic [1:0]       bus_addr,
   input logic [PIN_W-1:0] bus_wdata,
   input logic             bus_rmw,
   input logic [PIN_W-1:0] bus_rdata,
   input logic [PIN_W-1:0] pad_out,
   input logic [PIN_W-1:0] pad_oe,
   input logic [PIN_W-1:0] lcd_com_val,
   input logic             stop_mode,
   input logic             watch_mode,
   input logic [PIN_W-1:0] data_q,
   input logic [PIN_W-1:0] dir_q,
   input logic [PIN_W-1:0] fsel_q,
   input logic             pic_q,
   input logic             hold_q
);
   // R4: a data write lands in the latch on the next edge
   assert_latch_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 2'd0) |=> (data_q == $past(bus_wdata)));

   // R3: GPIO pins drive exactly when direction is 1 while the port is active
   assert_gpio_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pic_q && !((stop_mode || watch_mode) && hold_q))
         |-> ((pad_oe & ~fsel_q) == (dir_q & ~fsel_q)));

   // R3: a driving GPIO pin carries its latch bit
   assert_gpio_val_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out & pad_oe & ~fsel_q) == (data_q & pad_oe & ~fsel_q)));

   // R8: a driving LCD pin carries the LCD value
   assert_lcd_val_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out & pad_oe & fsel_q) == (lcd_com_val & pad_oe & fsel_q)));

   // R6: read-modify-write reads return the latch
   assert_rmw_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 2'd0 && bus_rmw) |-> (bus_rdata == data_q));

   // R7: input control off blocks drive and input
   assert_pic_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pic_q) |-> (pad_oe == '0));

   // R9: hold standby floats every pin and clamps inputs
   assert_hold_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((stop_mode || watch_mode) && hold_q) |-> (pad_oe == '0));

   assert_hold_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((stop_mode || watch_mode) && hold_q && bus_addr == 2'd0 && !bus_rmw)
         |-> ((bus_rdata & ~dir_q) == '0));
endmodule

bind gpio_port_standby gpio_port_chk #(.PIN_W(PIN_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_we      (bus_we),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .bus_rmw     (bus_rmw),
   .bus_rdata   (bus_rdata),
   .pad_out     (pad_out),
   .pad_oe      (pad_oe),
   .lcd_com_val (lcd_com_val),
   .stop_mode   (stop_mode),
   .watch_mode  (watch_mode),
   .data_q      (data_q),
   .dir_q       (dir_q),
   .fsel_q      (fsel_q),
   .pic_q       (pic_q),
   .hold_q      (hold_q)
);

// File: tb/gpio_port_standby_tb.sv
module gpio_port_standby_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_we = 1'b0;
   logic [1:0]   bus_addr = 2'd0;
   logic [W-1:0] bus_wdata = '0;
   logic         bus_rmw = 1'b0;
   logic [W-1:0] bus_rdata;
   logic [W-1:0] pad_in = '0;
   logic [W-1:0] pad_out, pad_oe;
   logic [W-1:0] lcd_com_val = '0;
   logic [W-1:0] lcd_com_oe = '0;
   logic         stop_mode = 1'b0;
   logic         watch_mode = 1'b0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_port_standby #(.PIN_W(W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rmw(bus_rmw), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .lcd_com_val(lcd_com_val), .lcd_com_oe(lcd_com_oe),
      .stop_mode(stop_mode), .watch_mode(watch_mode)
   );

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic rmw, output logic [W-1:0] d);
      bus_addr = a; bus_rmw = rmw;
      #1;
      d = bus_rdata;
      bus_rmw = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [W-1:0] v;
      rd(2'd0, 1'b1, v); check("R1 data", v, 8'h00);
      rd(2'd1, 1'b0, v); check("R1 dir", v, 8'h00);
      rd(2'd2, 1'b0, v); check("R1 fsel", v, 8'h00);
      rd(2'd3, 1'b0, v); check("R1 ctrl", v, 8'h01);
      check("R1 oe", pad_oe, 8'h00);
   endtask

   task automatic t_regmap();
      logic [W-1:0] v;
      wr(2'd2, 8'h5A); rd(2'd2, 1'b0, v); check("R2 fsel readback", v, 8'h5A);
      wr(2'd1, 8'hC3); rd(2'd1, 1'b0, v); check("R2 dir readback", v, 8'hC3);
      wr(2'd3, 8'hFE); rd(2'd3, 1'b0, v); check("R2 ctrl upper bits", v, 8'h02);
      wr(2'd3, 8'h01); wr(2'd2, 8'h00); wr(2'd1, 8'h00);
   endtask

   task automatic t_output();
      logic [W-1:0] v;
      wr(2'd1, 8'hFF); wr(2'd0, 8'h5A);
      check("R3 oe", pad_oe, 8'hFF);
      check("R3 out", pad_out, 8'h5A);
      wr(2'd1, 8'h00); wr(2'd0, 8'h96);
      check("R4 input no drive", pad_oe, 8'h00);
      rd(2'd0, 1'b1, v); check("R4 latch held", v, 8'h96);
      wr(2'd1, 8'h0F);
      check("R4 later drive oe", pad_oe, 8'h0F);
      check("R4 later drive val", pad_out & pad_oe, 8'h06);
   endtask

   task automatic t_input_read();
      logic [W-1:0] v;
      wr(2'd1, 8'h00); pad_in = 8'h00; settle();
      @(negedge clk); pad_in = 8'hA5;
      @(negedge clk); rd(2'd0, 1'b0, v); check("R5 one edge not yet", v, 8'h00);
      @(negedge clk); rd(2'd0, 1'b0, v); check("R5 two edges visible", v, 8'hA5);
      wr(2'd1, 8'hF0); wr(2'd0, 8'h3C);
      rd(2'd0, 1'b0, v); check("R5 mixed read", v, 8'h35);
   endtask

   task automatic t_rmw();
      logic [W-1:0] v;
      rd(2'd0, 1'b1, v); check("R6 rmw latch", v, 8'h3C);
      wr(2'd1, 8'h00);
      rd(2'd0, 1'b1, v); check("R6 rmw all inputs", v, 8'h3C);
      wr(2'd1, 8'hF0);
   endtask

   task automatic t_pic_off();
      logic [W-1:0] v;
      wr(2'd3, 8'h00);
      rd(2'd0, 1'b0, v); check("R7 input gated", v, 8'h30);
      check("R7 no drive", pad_oe, 8'h00);
      rd(2'd0, 1'b1, v); check("R7 rmw latch", v, 8'h3C);
      wr(2'd3, 8'h01);
   endtask

   task automatic t_lcd();
      wr(2'd0, 8'hFF); wr(2'd1, 8'h0F); wr(2'd2, 8'hF0);
      @(negedge clk); lcd_com_val = 8'hA0; lcd_com_oe = 8'hC0; #1;
      check("R8 lcd oe", pad_oe, 8'hCF);
      check("R8 lcd out", pad_out, 8'hAF);
      wr(2'd1, 8'hFF);
      check("R8 lcd dir1 no drive", pad_oe, 8'h0F);
      wr(2'd2, 8'h00); wr(2'd1, 8'h0F);
      lcd_com_val = '0; lcd_com_oe = '0;
   endtask

   task automatic t_standby_hold();
      logic [W-1:0] v;
      pad_in = 8'hFF; settle();
      wr(2'd3, 8'h03);
      @(negedge clk); stop_mode = 1'b1; #1;
      check("R9 stop oe", pad_oe, 8'h00);
      rd(2'd0, 1'b0, v); check("R9 stop clamp", v, 8'h0F);
      @(negedge clk); stop_mode = 1'b0; watch_mode = 1'b1; #1;
      check("R9 watch oe", pad_oe, 8'h00);
      rd(2'd0, 1'b0, v); check("R9 watch clamp", v, 8'h0F);
      @(negedge clk); watch_mode = 1'b0; #1;
      check("R9 release oe", pad_oe, 8'h0F);
   endtask

   task automatic t_standby_keep();
      logic [W-1:0] v;
      wr(2'd3, 8'h01);
      @(negedge clk); stop_mode = 1'b1; watch_mode = 1'b1; #1;
      check("R10 oe kept", pad_oe, 8'h0F);
      check("R10 out kept", pad_out & pad_oe, 8'h0F);
      rd(2'd0, 1'b0, v); check("R10 input kept", v, 8'hFF);
      @(negedge clk); stop_mode = 1'b0; watch_mode = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regmap();
      t_output();
      t_input_read();
      t_rmw();
      t_pic_off();
      t_lcd();
      t_standby_hold();
      t_standby_keep();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=0x00 expected=0x01");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule